// File: doc/BRIEF.md
# Multiplexed Eight-Digit LED Display Scanner

This block lights a row of eight common-anode seven-segment digits, each with a decimal point, using only two 8-bit output buses. The eight cathodes of the same name are tied together across all digits, and each digit has its own anode. Different glyphs can therefore appear on different digits only through time sharing. The block keeps one segment pattern per digit and shows the digits one after another. Each digit stays lit for a fixed number of clocks. Between two digits every anode is switched off for a short gap, so the old pattern never shows on the new digit.

A host loads patterns through a one-cycle write port that takes a digit index and a byte. A mode input picks how the stored byte is read. In raw mode the byte is a bitmap of segments. In hex mode the upper nibble is drawn as a hexadecimal glyph. Both dwell and gap lengths are parameters. The default dwell of 250000 clocks gives a full frame every 8 ms at a 250 MHz clock.

Top module: `led_scan_top`

## Requirements
- R1: In raw mode (hex_mode = 0), a stored bit of 1 means the segment is lit, and while a digit is shown seg_n equals the bitwise inverse of that digit's stored byte.
- R2: dig_en bit i enables digit i (bit 0 is the rightmost digit, bit 7 the leftmost), active high, and the digits are shown in ascending order 0, 1, ..., 7, 0, ...
- R3: Each digit stays enabled for exactly DWELL_CYCLES consecutive clocks.
- R4: At most one dig_en bit is high in any cycle.
- R5: Between two lit digits, dig_en is all zeros for exactly GAP_CYCLES clocks (GAP_CYCLES is at least 1). One enable is never replaced directly by another.
- R6: In every cycle in which dig_en is all zeros, seg_n is 8'hFF (all segments off).
- R7: A clock edge with rst high makes seg_n 8'hFF, makes dig_en 8'h00, and clears every stored pattern to zero. The first digit lit after reset is digit 0.
- R8: Segment byte layout, in both the stored byte and seg_n: bit 0 is the decimal point, and bits 1 to 7 are segments a, b, c, d, e, f, g in that order.
- R9: In hex mode (hex_mode = 1), stored bits 7:4 select a glyph, given as lit segments: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=abcdefg, 9=abcdfg, A=abcefg, b=cdefg, C=adef, d=bcdeg, E=adefg, F=aefg. Stored bit 0 still lights the decimal point, and stored bits 3:1 have no effect.
- R10: hex_mode is applied to the stored bytes as they are shown, so changing it changes the display without any new write.
- R11: A write with wr_en high replaces only the byte of digit wr_idx. All other digits keep their patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Pattern write strobe |
| wr_idx | input | 3 | Digit index for the write (0 = rightmost) |
| wr_data | input | 8 | Pattern byte to store |
| hex_mode | input | 1 | 1 = draw bits 7:4 as a hex glyph, 0 = raw segment bitmap |
| seg_n | output | 8 | Shared segment cathodes, active low (bit 0 = decimal point, bits 1 to 7 = a to g) |
| dig_en | output | 8 | Per-digit anode enables, active high (bit 0 = rightmost) |

## Verification
Some properties hold on every cycle and are checked by the bound assertions. These are: at most one enable high, no direct switch from one digit to another, dark segments whenever no digit is enabled, a dwell that never exceeds its limit, the digit order with its restart at digit 0 after reset, and the reset state. The directed scenarios cover what depends on stored content. They compare the shown segments with the written bytes in raw mode and against the glyph list in hex mode. They also check that the unused nibble bits and bytes of other digits are left untouched, and that a mode change takes effect without a rewrite. Exact dwell and gap lengths are measured by the bench.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    localparam int unsigned SEG_BITS = 8;

    typedef enum logic {
        PH_BLANK = 1'b0,
        PH_SHOW  = 1'b1
    } scan_phase_e;

    // Lit-segment view of one digit: bit 0 decimal point, bits 7:1 = g..a
    typedef struct packed {
        logic [6:0] gfedcba;
        logic       dp;
    } seg_lit_t;

    // Hex glyph, active-high, bit 0 = a ... bit 6 = g
    function automatic logic [6:0] hex_glyph(input logic [3:0] nib);
        logic [6:0] g;
        case (nib)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            default: g = 7'h71;
        endcase
        return g;
    endfunction

    function automatic seg_lit_t decode_pattern(input logic [SEG_BITS-1:0] pat,
                                                input logic hex);
        seg_lit_t r;
        if (hex) begin
            r.gfedcba = hex_glyph(pat[7:4]);
            r.dp      = pat[0];
        end else begin
            r = seg_lit_t'(pat);
        end
        return r;
    endfunction

endpackage

// File: rtl/led_scan_regfile.sv
module led_scan_regfile
    import led_scan_pkg::*;
#(
    parameter int unsigned DIGITS = 8,
    localparam int unsigned IDX_W = $clog2(DIGITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [SEG_BITS-1:0] wr_data,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [SEG_BITS-1:0] rd_data
);

    logic [SEG_BITS-1:0] slot_q [DIGITS];

    for (genvar d = 0; d < DIGITS; d++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[d] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(d))) begin
                slot_q[d] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/led_scan_seq.sv
module led_scan_seq
    import led_scan_pkg::*;
#(
    parameter int unsigned DIGITS       = 8,
    parameter int unsigned DWELL_CYCLES = 250000,
    parameter int unsigned GAP_CYCLES   = 1,
    localparam int unsigned IDX_W = $clog2(DIGITS),
    localparam int unsigned MAXC  = (DWELL_CYCLES > GAP_CYCLES) ? DWELL_CYCLES : GAP_CYCLES,
    localparam int unsigned CNT_W = $clog2(MAXC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    output scan_phase_e      phase,
    output logic [IDX_W-1:0] digit
);

    localparam logic [CNT_W-1:0] DWELL_LAST = CNT_W'(DWELL_CYCLES - 1);
    localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_CYCLES - 1);
    localparam logic [IDX_W-1:0] DIG_LAST   = IDX_W'(DIGITS - 1);

    scan_phase_e      phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] digit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_BLANK;
            cnt_q   <= '0;
            digit_q <= '0;
        end else begin
            unique case (phase_q)
                PH_BLANK: begin
                    if (cnt_q == GAP_LAST) begin
                        phase_q <= PH_SHOW;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_SHOW: begin
                    if (cnt_q == DWELL_LAST) begin
                        phase_q <= PH_BLANK;
                        cnt_q   <= '0;
                        digit_q <= (digit_q == DIG_LAST) ? '0 : digit_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_BLANK;
            endcase
        end
    end

    assign phase = phase_q;
    assign digit = digit_q;

endmodule

// File: rtl/led_scan_drive.sv
module led_scan_drive
    import led_scan_pkg::*;
#(
    parameter int unsigned DIGITS = 8,
    localparam int unsigned IDX_W = $clog2(DIGITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  scan_phase_e         phase,
    input  logic [IDX_W-1:0]    digit,
    input  logic [SEG_BITS-1:0] pattern,
    input  logic                hex_mode,
    output logic [SEG_BITS-1:0] seg_n,
    output logic [DIGITS-1:0]   dig_en
);

    seg_lit_t          lit;
    logic [DIGITS-1:0] en_next;

    assign lit     = decode_pattern(pattern, hex_mode);
    assign en_next = DIGITS'(1) << digit;

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_n  <= '1;
            dig_en <= '0;
        end else if (phase == PH_SHOW) begin
            seg_n  <= ~SEG_BITS'(lit);
            dig_en <= en_next;
        end else begin
            seg_n  <= '1;
            dig_en <= '0;
        end
    end

endmodule

// File: rtl/led_scan_top.sv
module led_scan_top
    import led_scan_pkg::*;
#(
    parameter int unsigned DIGITS       = 8,
    parameter int unsigned DWELL_CYCLES = 250000,
    parameter int unsigned GAP_CYCLES   = 1,
    localparam int unsigned IDX_W = $clog2(DIGITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [SEG_BITS-1:0] wr_data,
    input  logic                hex_mode,
    output logic [SEG_BITS-1:0] seg_n,
    output logic [DIGITS-1:0]   dig_en
);

    scan_phase_e         phase;
    logic [IDX_W-1:0]    digit;
    logic [SEG_BITS-1:0] pattern;

    led_scan_regfile #(.DIGITS(DIGITS)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (digit),
        .rd_data (pattern)
    );

    led_scan_seq #(
        .DIGITS       (DIGITS),
        .DWELL_CYCLES (DWELL_CYCLES),
        .GAP_CYCLES   (GAP_CYCLES)
    ) seq_i (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .digit (digit)
    );

    led_scan_drive #(.DIGITS(DIGITS)) drive_i (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .digit    (digit),
        .pattern  (pattern),
        .hex_mode (hex_mode),
        .seg_n    (seg_n),
        .dig_en   (dig_en)
    );

endmodule

// File: rtl/led_scan_checker.sv
module led_scan_checker #(
    parameter int unsigned DIGITS       = 8,
    parameter int unsigned DWELL_CYCLES = 250000
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        seg_n,
    input logic [DIGITS-1:0] dig_en
);

    logic [DIGITS-1:0] prev_en;
    logic [DIGITS-1:0] last_lit;
    int unsigned       run_cnt;
    logic [DIGITS-1:0] expect_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_en  <= '0;
            last_lit <= '0;
            run_cnt  <= 0;
        end else begin
            prev_en <= dig_en;
            if (dig_en != '0) begin
                last_lit <= dig_en;
                run_cnt  <= (dig_en == prev_en) ? run_cnt + 1 : 1;
            end else begin
                run_cnt <= 0;
            end
        end
    end

    assign expect_en = (last_lit == '0) ? DIGITS'(1)
                                        : {last_lit[DIGITS-2:0], last_lit[DIGITS-1]};

    // R4: never two digits at once
    assert_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dig_en));

    // R5: a lit digit is followed by itself or by darkness
    assert_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (dig_en != '0) |=> (dig_en == '0 || $stable(dig_en)));

    // R6: segments dark while no anode is driven
    assert_dark_blank_R6: assert property (@(posedge clk) disable iff (rst)
        (dig_en == '0) |-> (seg_n == 8'hFF));

    // R3: a run never exceeds the dwell length
    assert_dwell_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (dig_en != '0 && dig_en == prev_en) |-> (run_cnt < DWELL_CYCLES));

    // R2 / R7: next digit is the left neighbour, digit 0 after reset
    assert_order_R2: assert property (@(posedge clk) disable iff (rst)
        (dig_en != '0 && prev_en == '0) |-> (dig_en == expect_en));

    // R7: reset state
    assert_reset_state_R7: assert property (@(posedge clk)
        rst |=> (seg_n == 8'hFF && dig_en == '0));

endmodule

bind led_scan_top led_scan_checker #(
    .DIGITS       (DIGITS),
    .DWELL_CYCLES (DWELL_CYCLES)
) checker_i (
    .clk    (clk),
    .rst    (rst),
    .seg_n  (seg_n),
    .dig_en (dig_en)
);

// File: tb/led_scan_top_tb_top.sv
`timescale 1ns/1ps
module led_scan_top_tb_top;

    localparam int DWELL = 5;
    localparam int GAP   = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic       hex_mode = 1'b0;
    logic [7:0] seg_n;
    logic [7:0] dig_en;

    int checks = 0;
    int errors = 0;
    logic [7:0] stored [8];

    always #2 clk = ~clk;

    led_scan_top #(.DIGITS(8), .DWELL_CYCLES(DWELL), .GAP_CYCLES(GAP)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .hex_mode(hex_mode), .seg_n(seg_n), .dig_en(dig_en)
    );

    // Glyphs from R9, active high, bit 0 = a ... bit 6 = g
    function automatic logic [6:0] ref_glyph(input logic [3:0] n);
        case (n)
            4'h0: return 7'b0111111; 4'h1: return 7'b0000110;
            4'h2: return 7'b1011011; 4'h3: return 7'b1001111;
            4'h4: return 7'b1100110; 4'h5: return 7'b1101101;
            4'h6: return 7'b1111101; 4'h7: return 7'b0000111;
            4'h8: return 7'b1111111; 4'h9: return 7'b1101111;
            4'hA: return 7'b1110111; 4'hB: return 7'b1111100;
            4'hC: return 7'b0111001; 4'hD: return 7'b1011110;
            4'hE: return 7'b1111001; default: return 7'b1110001;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_pat(input int idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_data = d;
        stored[idx] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_digit(input int k);
        do @(negedge clk); while (dig_en != 8'h00);
        do @(negedge clk); while (dig_en != (8'(1) << k));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 seg_n in reset", seg_n, 8'hFF);
        check("R7 dig_en in reset", dig_en, 8'h00);
        rst = 1'b0;
        do @(negedge clk); while (dig_en == 8'h00);
        check("R7 first digit after reset", dig_en, 8'h01);
        check("R7 cleared pattern dark", seg_n, 8'hFF);
        for (int i = 0; i < 8; i++) stored[i] = 8'h00;
    endtask

    task automatic t_raw();
        hex_mode = 1'b0;
        for (int k = 0; k < 8; k++) write_pat(k, 8'(8'h11 * (k + 1)) ^ 8'h5A);
        write_pat(2, 8'h01);  // decimal point only, R8 bit 0
        write_pat(6, 8'h02);  // segment a only, R8 bit 1
        write_pat(7, 8'h80);  // segment g only, R8 bit 7
        for (int k = 0; k < 8; k++) begin
            wait_digit(k);
            check($sformatf("R1 R8 raw digit %0d", k), seg_n, ~stored[k]);
        end
    endtask

    task automatic t_order();
        int prev = -1;
        do @(negedge clk); while (dig_en != 8'h00);
        for (int n = 0; n < 10; n++) begin
            int cur = -1;
            do @(negedge clk); while (dig_en == 8'h00);
            for (int i = 0; i < 8; i++) if (dig_en == (8'(1) << i)) cur = i;
            if (prev >= 0) check("R2 digit order", 8'(cur), 8'((prev + 1) % 8));
            prev = cur;
            do @(negedge clk); while (dig_en != 8'h00);
        end
    endtask

    task automatic t_timing();
        int run = 1;
        int gap = 0;
        logic dark_ok = 1'b1;
        wait_digit(3);
        @(negedge clk);
        while (dig_en == 8'h08) begin run++; @(negedge clk); end
        check("R3 dwell length", 8'(run), 8'(DWELL));
        while (dig_en == 8'h00) begin
            gap++;
            if (seg_n != 8'hFF) dark_ok = 1'b0;
            @(negedge clk);
        end
        check("R5 gap length", 8'(gap), 8'(GAP));
        check("R6 segments dark in gap", {7'd0, dark_ok}, 8'h01);
        check("R2 R5 digit after gap", dig_en, 8'h10);
    endtask

    task automatic t_hex();
        hex_mode = 1'b1;
        for (int r = 0; r < 2; r++) begin
            for (int k = 0; k < 8; k++)
                write_pat(k, {4'(r * 8 + k), 3'b101, 1'(k % 2)});  // bits 3:1 junk
            for (int k = 0; k < 8; k++) begin
                wait_digit(k);
                check($sformatf("R9 hex glyph %0d", r * 8 + k), seg_n,
                      ~{ref_glyph(4'(r * 8 + k)), 1'(k % 2)});
            end
        end
    endtask

    task automatic t_live_mode();
        hex_mode = 1'b0;
        wait_digit(4);
        check("R10 mode switch without write", seg_n, ~stored[4]);
        hex_mode = 1'b1;
        wait_digit(4);
        check("R10 mode back to hex", seg_n, ~{ref_glyph(stored[4][7:4]), stored[4][0]});
    endtask

    task automatic t_isolation();
        hex_mode = 1'b0;
        write_pat(5, 8'h81);
        wait_digit(4);
        check("R11 neighbour untouched", seg_n, ~stored[4]);
        wait_digit(5);
        check("R11 addressed digit updated", seg_n, 8'h7E);
        wait_digit(6);
        check("R11 other neighbour untouched", seg_n, ~stored[6]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_raw();
        t_order();
        t_timing();
        t_hex();
        t_live_mode();
        t_isolation();
        t_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule